// File: doc/BRIEF.md
# Crystal Clock Failure Detector with Switchover

This block checks a fast crystal oscillator clock against a slow RC reference clock that always runs. In each high phase of the reference it counts the fast clock periods. A phase with too few of them, or none at all because the crystal has stopped, is a failure. Detection works even when the fast clock has stopped completely. The block then reports the failure in three ways: a live status bit, a sticky event flag with a maskable interrupt, and a fault line that a motor-control PWM block uses to force its outputs safe.

On a failure the block takes over the clock muxes. First it turns on the fast internal RC oscillator. Then it moves the main clock mux onto that oscillator. If the crystal feeds the main clock and the master clock runs from a PLL, the master clock mux is first moved onto the main clock, one reference cycle before the main mux switches. The overrides stay in force until software turns the detector off, or writes new mux selections once the failure has gone.

All register-style strobes (status read, fault clear, selection write) are synchronous to the reference clock. Each is seen on one rising reference edge.

Top module: `xtal_fail_guard`

## Requirements
- R1: A reference high phase with fewer than THRESH (default 8) fast clock periods counts as a failing window. A fast clock with 16 periods per high phase never raises `fail_live`. A fast clock with about 3 periods per high phase raises it.
- R2: When the fast clock stops at any point, `fail_live` rises within 5 reference periods.
- R3: `fail_live` shows the present condition. It is low after reset and falls within 8 reference periods once a healthy fast clock returns.
- R4: `fail_evt` is set on the reference edge where `fail_live` rises. It stays set until a `stat_rd` strobe arrives with no new failure starting. A read on the same edge as a new failure leaves it set.
- R5: `irq` is high exactly when `fail_evt` is high and `irq_en` is 1.
- R6: `rc_on_force` (fast RC oscillator enable) rises on the same edge as `fail_live`.
- R7: When the crystal is not selected, or `mck_src` is 0 (slow) or 1 (main), `force_main_rc` rises one reference edge after `fail_live`.
- R8: When `xtal_sel`=1 and `mck_src` is 2 or 3 (PLL), `force_mck_main` rises one edge after `fail_live` and `force_main_rc` rises one edge after that.
- R9: `force_mck_main` stays low unless the condition of R8 held when the failure began.
- R10: `fault_out` is set with `fail_live`. It is cleared by a `fault_clr` strobe only while `fail_live` is low. A clear strobe during a failure has no effect.
- R11: The three overrides stay set until `det_en` goes low, or until a `sel_wr` strobe arrives while `fail_live` is low. A `sel_wr` during a failure is ignored.
- R12: While `det_en` is low, no failure is flagged. Dropping `det_en` clears `fail_live` and all overrides on the next reference edge. Detection arms WARM (default 3) reference cycles after `det_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Crystal oscillator clock under watch |
| clk_ref | input | 1 | Slow RC reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| det_en | input | 1 | Detector enable |
| xtal_sel | input | 1 | 1 when the main clock mux selects the crystal |
| mck_src | input | 2 | Master clock source: 0 slow, 1 main, 2 and 3 PLL |
| irq_en | input | 1 | Interrupt enable (0 = masked) |
| stat_rd | input | 1 | Status read strobe, clears `fail_evt` |
| fault_clr | input | 1 | Fault clear strobe |
| sel_wr | input | 1 | Software write of new mux selections, releases overrides |
| fail_live | output | 1 | Live failure status |
| fail_evt | output | 1 | Sticky failure event flag |
| irq | output | 1 | Failure interrupt |
| rc_on_force | output | 1 | Forces the fast RC oscillator on |
| force_main_rc | output | 1 | Forces the main clock mux to the fast RC oscillator |
| force_mck_main | output | 1 | Forces the master clock mux to the main clock |
| fault_out | output | 1 | Fault line to the PWM block |

## Verification
The detector is driven with four fast clock patterns. A healthy 125 MHz clock shows that good windows raise no alarm. A clock that stops in the middle of a reference high phase shows whether detection still works with no fast edges at all. A clock slowed to a 40 ns period still toggles, but gives too few periods per window, which tests the count threshold itself. A clock that restarts after a stop shows whether the live bit recovers while the sticky state stays. The onset is run once with the master on the main clock and once on a PLL, to tell the one-step switch from the two-step one. A status read held across a failure onset separates set priority from clear. Clear and write strobes issued during and after a failure check the release rules.

// File: rtl/xfg_pkg.sv
package xfg_pkg;

   typedef enum logic [1:0] {
      MCK_SLOW = 2'd0,
      MCK_MAIN = 2'd1,
      MCK_PLL0 = 2'd2,
      MCK_PLL1 = 2'd3
   } mck_src_e;

   function automatic logic from_pll(input logic [1:0] src);
      return (mck_src_e'(src) == MCK_PLL0) || (mck_src_e'(src) == MCK_PLL1);
   endfunction

endpackage

// File: rtl/xfg_sync.sv
module xfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xfg_win_cnt.sv
// Fast-domain window counter: counts fast periods while the synchronised
// reference is high and toggles ok_tog once per window that reaches THRESH.
module xfg_win_cnt #(
   parameter int THRESH = 8,
   parameter int SYNC   = 2
) (
   input  logic clk_fast,
   input  logic rst_n,
   input  logic ref_in,
   output logic ok_tog
);
   localparam int CNT_W = $clog2(THRESH + 1);

   logic             ref_s, ref_q, ref_rise;
   logic [CNT_W-1:0] cnt_q;

   xfg_sync #(.STAGES(SYNC)) u_ref_sync (
      .clk   (clk_fast),
      .rst_n (rst_n),
      .d     (ref_in),
      .q     (ref_s)
   );

   assign ref_rise = ref_s && !ref_q;

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= 1'b0;
         cnt_q  <= '0;
         ok_tog <= 1'b0;
      end else begin
         ref_q <= ref_s;
         if (ref_rise) begin
            cnt_q <= '0;
         end else if (ref_s && (cnt_q != CNT_W'(THRESH))) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(THRESH - 1)) ok_tog <= !ok_tog;
         end
      end
   end
endmodule

// File: rtl/xfg_ctl.sv
// Reference-domain control: staleness test, flags and mux overrides.
module xfg_ctl
   import xfg_pkg::*;
#(
   parameter int WARM = 3
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       tog_s,
   input  logic       det_en,
   input  logic       xtal_sel,
   input  logic [1:0] mck_src,
   input  logic       stat_rd,
   input  logic       fault_clr,
   input  logic       sel_wr,
   output logic       fail_live,
   output logic       fail_evt,
   output logic       rc_on_force,
   output logic       force_main_rc,
   output logic       force_mck_main,
   output logic       fault_out
);
   localparam int WARM_W = $clog2(WARM + 1);

   logic [WARM_W-1:0] warm_q;
   logic seen_q, step1_q, step2_q, pll_q;
   logic armed, stale, fail_nxt, set_fail, release_ov;

   always_comb begin
      armed      = (warm_q == WARM_W'(WARM));
      stale      = (tog_s == seen_q);
      fail_nxt   = det_en && armed && stale;
      set_fail   = fail_nxt && !fail_live;
      release_ov = !det_en || (sel_wr && !fail_live && !fail_nxt);
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         warm_q         <= '0;
         seen_q         <= 1'b0;
         step1_q        <= 1'b0;
         step2_q        <= 1'b0;
         pll_q          <= 1'b0;
         fail_live      <= 1'b0;
         fail_evt       <= 1'b0;
         fault_out      <= 1'b0;
         rc_on_force    <= 1'b0;
         force_main_rc  <= 1'b0;
         force_mck_main <= 1'b0;
      end else begin
         seen_q <= tog_s;
         if (!det_en)     warm_q <= '0;
         else if (!armed) warm_q <= warm_q + 1'b1;

         fail_live <= fail_nxt;
         step1_q   <= set_fail;
         step2_q   <= step1_q;
         if (set_fail) pll_q <= xtal_sel && from_pll(mck_src);

         if (set_fail)     fail_evt <= 1'b1;
         else if (stat_rd) fail_evt <= 1'b0;

         if (set_fail)                     fault_out <= 1'b1;
         else if (fault_clr && !fail_live) fault_out <= 1'b0;

         if (release_ov) begin
            rc_on_force    <= 1'b0;
            force_main_rc  <= 1'b0;
            force_mck_main <= 1'b0;
         end else begin
            if (set_fail) rc_on_force <= 1'b1;
            if (step1_q) begin
               if (pll_q) force_mck_main <= 1'b1;
               else       force_main_rc  <= 1'b1;
            end
            if (step2_q && pll_q) force_main_rc <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/xtal_fail_guard.sv
module xtal_fail_guard #(
   parameter int THRESH    = 8,
   parameter int SYNC_FAST = 2,
   parameter int SYNC_REF  = 2,
   parameter int WARM      = 3
) (
   input  logic       clk_fast,
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       det_en,
   input  logic       xtal_sel,
   input  logic [1:0] mck_src,
   input  logic       irq_en,
   input  logic       stat_rd,
   input  logic       fault_clr,
   input  logic       sel_wr,
   output logic       fail_live,
   output logic       fail_evt,
   output logic       irq,
   output logic       rc_on_force,
   output logic       force_main_rc,
   output logic       force_mck_main,
   output logic       fault_out
);
   generate
      if (THRESH < 2) begin : g_bad_thresh
         $error("xtal_fail_guard: THRESH must be at least 2");
      end
      if (WARM < SYNC_REF) begin : g_bad_warm
         $error("xtal_fail_guard: WARM must cover the reference synchroniser");
      end
   endgenerate

   logic ok_tog, tog_s;

   xfg_win_cnt #(.THRESH(THRESH), .SYNC(SYNC_FAST)) u_cnt (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .ref_in   (clk_ref),
      .ok_tog   (ok_tog)
   );

   xfg_sync #(.STAGES(SYNC_REF)) u_tog_sync (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .d     (ok_tog),
      .q     (tog_s)
   );

   xfg_ctl #(.WARM(WARM)) u_ctl (
      .clk_ref        (clk_ref),
      .rst_n          (rst_n),
      .tog_s          (tog_s),
      .det_en         (det_en),
      .xtal_sel       (xtal_sel),
      .mck_src        (mck_src),
      .stat_rd        (stat_rd),
      .fault_clr      (fault_clr),
      .sel_wr         (sel_wr),
      .fail_live      (fail_live),
      .fail_evt       (fail_evt),
      .rc_on_force    (rc_on_force),
      .force_main_rc  (force_main_rc),
      .force_mck_main (force_mck_main),
      .fault_out      (fault_out)
   );

   assign irq = fail_evt && irq_en;
endmodule

// File: rtl/xfg_chk.sv
module xfg_chk (
   input logic       clk_ref,
   input logic       rst_n,
   input logic       det_en,
   input logic       xtal_sel,
   input logic [1:0] mck_src,
   input logic       irq_en,
   input logic       fail_live,
   input logic       fail_evt,
   input logic       irq,
   input logic       rc_on_force,
   input logic       force_main_rc,
   input logic       force_mck_main,
   input logic       fault_out
);
   // R4
   evt_on_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(fail_live) |-> fail_evt);

   // R5
   irq_gate_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      irq |-> (fail_evt && irq_en));

   // R6
   rc_enable_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      fail_live |-> rc_on_force);

   // R7
   main_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($rose(fail_live) && !($past(xtal_sel) && $past(mck_src[1])))
      |=> (force_main_rc || !det_en));

   // R8
   pll_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($rose(fail_live) && $past(xtal_sel) && $past(mck_src[1]))
      |=> ((force_mck_main && !force_main_rc) || !det_en));

   // R10
   fault_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      fail_live |-> fault_out);

   // R12
   det_off_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !det_en |=> (!fail_live && !rc_on_force && !force_main_rc && !force_mck_main));
endmodule

bind xtal_fail_guard xfg_chk u_chk (
   .clk_ref        (clk_ref),
   .rst_n          (rst_n),
   .det_en         (det_en),
   .xtal_sel       (xtal_sel),
   .mck_src        (mck_src),
   .irq_en         (irq_en),
   .fail_live      (fail_live),
   .fail_evt       (fail_evt),
   .irq            (irq),
   .rc_on_force    (rc_on_force),
   .force_main_rc  (force_main_rc),
   .force_mck_main (force_mck_main),
   .fault_out      (fault_out)
);

// File: tb/sim_xtal_fail_guard.sv
module sim_xtal_fail_guard;
   logic       clk_fast = 1'b0;
   logic       clk_ref  = 1'b0;
   logic       rst_n    = 1'b0;
   logic       det_en   = 1'b0;
   logic       xtal_sel = 1'b1;
   logic [1:0] mck_src  = 2'd1;
   logic       irq_en   = 1'b1;
   logic       stat_rd  = 1'b0;
   logic       fault_clr = 1'b0;
   logic       sel_wr   = 1'b0;
   logic       fail_live, fail_evt, irq, rc_on_force, force_main_rc, force_mck_main, fault_out;

   bit      fast_on   = 1'b1;
   realtime fast_half = 4ns;
   int      total = 0;
   int      bad   = 0;

   always begin
      #(fast_half);
      if (fast_on) clk_fast = ~clk_fast;
   end

   always #128ns clk_ref = ~clk_ref;

   xtal_fail_guard u0 (
      .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n), .det_en(det_en),
      .xtal_sel(xtal_sel), .mck_src(mck_src), .irq_en(irq_en), .stat_rd(stat_rd),
      .fault_clr(fault_clr), .sel_wr(sel_wr), .fail_live(fail_live), .fail_evt(fail_evt),
      .irq(irq), .rc_on_force(rc_on_force), .force_main_rc(force_main_rc),
      .force_mck_main(force_mck_main), .fault_out(fault_out)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_ref);
   endtask

   task automatic pulse_rd();    stat_rd = 1'b1;   tick(); stat_rd = 1'b0;   endtask
   task automatic pulse_clr();   fault_clr = 1'b1; tick(); fault_clr = 1'b0; endtask
   task automatic pulse_sel();   sel_wr = 1'b1;    tick(); sel_wr = 1'b0;    endtask

   task automatic stop_mid();
      @(posedge clk_ref);
      #60ns;
      fast_on = 1'b0;
   endtask

   task automatic wait_level(input bit lvl, output int n);
      n = 0;
      for (int i = 1; i <= 10; i++) begin
         tick();
         if (fail_live == lvl) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic cleanup();
      int n;
      fast_half = 4ns;
      fast_on   = 1'b1;
      det_en    = 1'b1;
      wait_level(1'b0, n);
      pulse_clr();
      pulse_sel();
      pulse_rd();
   endtask

   task automatic t_reset();
      chk("R3", "fail_live in reset", int'(fail_live), 0);
      chk("R4", "fail_evt in reset", int'(fail_evt), 0);
      chk("R10", "fault_out in reset", int'(fault_out), 0);
      chk("R11", "overrides in reset", int'({rc_on_force, force_main_rc, force_mck_main}), 0);
   endtask

   task automatic t_healthy();
      int seen = 0;
      det_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         tick();
         if (fail_live || rc_on_force) seen++;
      end
      chk("R1", "healthy clock raises nothing", seen, 0);
   endtask

   task automatic t_stop_main();
      int n;
      xtal_sel = 1'b1; mck_src = 2'd1; irq_en = 1'b1;
      stop_mid();
      wait_level(1'b1, n);
      chk("R2", "detect within 5 periods", int'(n >= 1 && n <= 5), 1);
      chk("R6", "rc_on_force with fail_live", int'(rc_on_force), 1);
      chk("R7", "main mux not yet forced", int'(force_main_rc), 0);
      chk("R4", "event set at onset", int'(fail_evt), 1);
      chk("R5", "irq with enable", int'(irq), 1);
      chk("R10", "fault set at onset", int'(fault_out), 1);
      tick();
      chk("R7", "main mux forced one edge later", int'(force_main_rc), 1);
      chk("R9", "master not forced from main", int'(force_mck_main), 0);
   endtask

   task automatic t_read_and_hold();
      pulse_rd();
      chk("R4", "read clears event", int'(fail_evt), 0);
      chk("R5", "irq follows event", int'(irq), 0);
      chk("R3", "live bit stays during failure", int'(fail_live), 1);
      pulse_clr();
      chk("R10", "clear ignored during failure", int'(fault_out), 1);
      pulse_sel();
      chk("R11", "sel_wr ignored during failure", int'(force_main_rc), 1);
   endtask

   task automatic t_restart();
      int n;
      fast_on = 1'b1;
      wait_level(1'b0, n);
      chk("R3", "live bit clears after restart", int'(n >= 1 && n <= 8), 1);
      chk("R10", "fault held after recovery", int'(fault_out), 1);
      chk("R11", "overrides held after recovery", int'(force_main_rc && rc_on_force), 1);
      pulse_clr();
      chk("R10", "fault cleared after recovery", int'(fault_out), 0);
      pulse_sel();
      chk("R11", "sel_wr releases overrides", int'({rc_on_force, force_main_rc, force_mck_main}), 0);
   endtask

   task automatic t_pll();
      int n;
      xtal_sel = 1'b1; mck_src = 2'd2;
      stop_mid();
      wait_level(1'b1, n);
      chk("R8", "onset: no mux forced yet", int'({force_mck_main, force_main_rc}), 0);
      tick();
      chk("R8", "master forced first", int'({force_mck_main, force_main_rc}), 2);
      tick();
      chk("R8", "main forced second", int'({force_mck_main, force_main_rc}), 3);
      cleanup();
      mck_src = 2'd1;
   endtask

   task automatic t_slow_same_read();
      int n;
      xtal_sel = 1'b0; mck_src = 2'd3; irq_en = 1'b0;
      stat_rd = 1'b1;
      fast_half = 20ns;
      wait_level(1'b1, n);
      chk("R1", "slow clock detected", int'(n >= 1), 1);
      chk("R4", "read on onset edge keeps event", int'(fail_evt), 1);
      chk("R5", "masked irq stays low", int'(irq), 0);
      tick();
      stat_rd = 1'b0;
      chk("R4", "held read clears next edge", int'(fail_evt), 0);
      chk("R9", "no master force without crystal", int'(force_mck_main), 0);
      chk("R7", "main forced when crystal not selected", int'(force_main_rc), 1);
      cleanup();
      xtal_sel = 1'b1; mck_src = 2'd1; irq_en = 1'b1;
   endtask

   task automatic t_disable();
      int n;
      int seen = 0;
      det_en = 1'b0;
      tick();
      fast_on = 1'b0;
      for (int i = 0; i < 8; i++) begin
         tick();
         if (fail_live || fail_evt) seen++;
      end
      chk("R12", "no detection while disabled", seen, 0);
      det_en = 1'b1;
      wait_level(1'b1, n);
      chk("R12", "arms after enable", int'(n >= 3 && n <= 5), 1);
      tick(); tick();
      det_en = 1'b0;
      tick();
      chk("R12", "disable clears live and overrides",
          int'({fail_live, rc_on_force, force_main_rc, force_mck_main}), 0);
      cleanup();
   endtask

   initial begin
      #1ms;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick();
      t_reset();
      tick();
      rst_n = 1'b1;
      t_healthy();
      t_stop_main();
      t_read_and_hold();
      t_restart();
      t_pll();
      t_slow_same_read();
      t_disable();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule